// File: doc/BRIEF.md
# Software Flow Control Monitor

This block sits between a serial receiver and its transmitter. Each byte the receiver delivers is compared against four programmable patterns: two resume patterns and two pause patterns. A recognised pause pattern stops the local transmitter, and a recognised resume pattern lets it run again. The comparison works beside the receive data path and does not change the bytes on it. A flag output marks the byte that completed a match, so the surrounding logic can drop that byte from the data stream if it wants to.

A two-bit mode input selects how matching works. The block can match on one character, on two consecutive characters, or on one character against either pattern of a pair. A separate enable lets any received byte resume a paused transmitter. The pause takes effect only when the transmitter reports that it is between characters, so a character that is already being shifted out always finishes.

Top module: `swflow_ctl`

## Requirements
- R1: After reset, tx_enable is 1, flow_suspended is 0, and xon_pulse, xoff_pulse and rx_is_flow are all 0.
- R2: cfg_mode encodings: 00 off, 01 single, 10 pair, 11 either. While the mode is 00, one cycle later tx_enable is 1 and flow_suspended is 0, and no received byte raises a pulse.
- R3: In mode 01, a received byte equal to cfg_xoff1 sets flow_suspended, and one equal to cfg_xon1 clears it. Both take effect on the clock edge that samples rx_valid.
- R4: When a byte completes both a pause match and a resume match, the pause wins: xoff_pulse is 1, xon_pulse is 0, and flow_suspended is set.
- R5: In mode 10, a pause needs cfg_xoff1 followed by cfg_xoff2 as consecutive received bytes, and a resume needs cfg_xon1 followed by cfg_xon2. The first byte alone changes nothing.
- R6: In mode 10, when the byte after a first-pattern byte differs from the second pattern, the partial match is dropped. That byte is then checked again as a possible first byte.
- R7: In mode 11, a single byte equal to cfg_xoff1 or cfg_xoff2 pauses, and a single byte equal to cfg_xon1 or cfg_xon2 resumes.
- R8: With cfg_xon_any at 1, any received byte resumes a paused transmitter and raises xon_pulse. Such a byte raises rx_is_flow only if it matches a pattern. A byte received while not paused raises no pulse.
- R9: With cfg_xon_any at 0, a byte that does not complete a resume match leaves a paused transmitter paused.
- R10: tx_enable falls on the edge after a cycle in which flow_suspended and tx_char_boundary are both 1, and at no other time. It rises on the edge after flow_suspended clears.
- R11: xon_pulse, xoff_pulse and rx_is_flow are single-cycle pulses in the cycle after the byte is received. rx_is_flow marks a byte that completes a pattern match, and the two pulses are never high together.
- R12: Leaving mode 10 for mode 00 discards any partial match, so a second-pattern byte that arrives after the return to mode 10 completes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | DATA_W | Received byte |
| cfg_xon1 | input | DATA_W | First resume pattern |
| cfg_xon2 | input | DATA_W | Second resume pattern |
| cfg_xoff1 | input | DATA_W | First pause pattern |
| cfg_xoff2 | input | DATA_W | Second pause pattern |
| cfg_mode | input | 2 | Matching mode (00 off, 01 single, 10 pair, 11 either) |
| cfg_xon_any | input | 1 | Any received byte resumes a paused transmitter |
| tx_char_boundary | input | 1 | High while the transmitter is between characters |
| tx_enable | output | 1 | Transmitter may start a new character |
| xon_pulse | output | 1 | Resume event |
| xoff_pulse | output | 1 | Pause event |
| flow_suspended | output | 1 | Flow state: 1 while paused |
| rx_is_flow | output | 1 | Byte just received completed a pattern match |

## Verification
The bench targets the pair mode's broken sequences: a repeated first pause byte followed by the second pattern, and a foreign byte placed between the two resume bytes. A design that failed to re-check the breaking byte would miss the pause, and one that kept stale partial state would resume when it should not. Other tests program the same value as both a pause and a resume pattern to expose a wrong priority, and hold the character boundary low to catch a transmitter cut off in the middle of a character. Further tests leave mode 10 between the two bytes of a pair, where a design that keeps its partial state would pause after the return, and enable resume-on-any-byte, where a flag raised on a plain data byte would be reported.

// File: rtl/swflow_pkg.sv
package swflow_pkg;
   typedef enum logic [1:0] {
      FC_OFF    = 2'b00,
      FC_SINGLE = 2'b01,
      FC_PAIR   = 2'b10,
      FC_EITHER = 2'b11
   } fc_mode_e;

   localparam int NUM_PAT  = 4;
   localparam int PAT_ON1  = 0;
   localparam int PAT_ON2  = 1;
   localparam int PAT_OFF1 = 2;
   localparam int PAT_OFF2 = 3;
endpackage

// File: rtl/swflow_cmp.sv
module swflow_cmp
   import swflow_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]              byte_in,
   input  logic [NUM_PAT-1:0][DATA_W-1:0] pats,
   output logic [NUM_PAT-1:0]             eq
);
   for (genvar g = 0; g < NUM_PAT; g++) begin : g_cmp
      assign eq[g] = (byte_in == pats[g]);
   end
endmodule

// File: rtl/swflow_seq.sv
module swflow_seq
   import swflow_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  fc_mode_e           mode,
   input  logic [NUM_PAT-1:0] eq,
   output logic               on_hit,
   output logic               off_hit
);
   logic pend_on_q, pend_off_q;
   logic on_raw, off_raw;

   always_comb begin
      on_raw  = 1'b0;
      off_raw = 1'b0;
      unique case (mode)
         FC_SINGLE: begin
            on_raw  = eq[PAT_ON1];
            off_raw = eq[PAT_OFF1];
         end
         FC_PAIR: begin
            on_raw  = pend_on_q  & eq[PAT_ON2];
            off_raw = pend_off_q & eq[PAT_OFF2];
         end
         FC_EITHER: begin
            on_raw  = eq[PAT_ON1]  | eq[PAT_ON2];
            off_raw = eq[PAT_OFF1] | eq[PAT_OFF2];
         end
         default: ;
      endcase
   end

   assign on_hit  = rx_valid & on_raw;
   assign off_hit = rx_valid & off_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_on_q  <= 1'b0;
         pend_off_q <= 1'b0;
      end else if (mode != FC_PAIR) begin
         pend_on_q  <= 1'b0;
         pend_off_q <= 1'b0;
      end else if (rx_valid) begin
         pend_on_q  <= ~(on_raw | off_raw) & eq[PAT_ON1];
         pend_off_q <= ~(on_raw | off_raw) & eq[PAT_OFF1];
      end
   end
endmodule

// File: rtl/swflow_gate.sv
module swflow_gate
   import swflow_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mode_off,
   input  logic rx_valid,
   input  logic on_hit,
   input  logic off_hit,
   input  logic xon_any,
   input  logic boundary,
   output logic suspended,
   output logic tx_en,
   output logic on_pulse,
   output logic off_pulse,
   output logic flow_flag
);
   logic any_resume, do_off, do_on;

   assign any_resume = xon_any & suspended & rx_valid & ~mode_off;
   assign do_off     = off_hit;
   assign do_on      = ~off_hit & (on_hit | any_resume);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         suspended <= 1'b0;
         tx_en     <= 1'b1;
         on_pulse  <= 1'b0;
         off_pulse <= 1'b0;
         flow_flag <= 1'b0;
      end else begin
         if (mode_off)     suspended <= 1'b0;
         else if (do_off)  suspended <= 1'b1;
         else if (do_on)   suspended <= 1'b0;

         if (mode_off || !suspended) tx_en <= 1'b1;
         else if (boundary)          tx_en <= 1'b0;

         on_pulse  <= do_on;
         off_pulse <= do_off;
         flow_flag <= on_hit | off_hit;
      end
   end
endmodule

// File: rtl/swflow_ctl.sv
module swflow_ctl
   import swflow_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [DATA_W-1:0] cfg_xon1,
   input  logic [DATA_W-1:0] cfg_xon2,
   input  logic [DATA_W-1:0] cfg_xoff1,
   input  logic [DATA_W-1:0] cfg_xoff2,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_xon_any,
   input  logic              tx_char_boundary,
   output logic              tx_enable,
   output logic              xon_pulse,
   output logic              xoff_pulse,
   output logic              flow_suspended,
   output logic              rx_is_flow
);
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("swflow_ctl: DATA_W must lie in 5..9");
   end

   logic [NUM_PAT-1:0][DATA_W-1:0] pats;
   logic [NUM_PAT-1:0]             eq;
   logic                           on_hit, off_hit;
   fc_mode_e                       mode;

   assign mode           = fc_mode_e'(cfg_mode);
   assign pats[PAT_ON1]  = cfg_xon1;
   assign pats[PAT_ON2]  = cfg_xon2;
   assign pats[PAT_OFF1] = cfg_xoff1;
   assign pats[PAT_OFF2] = cfg_xoff2;

   swflow_cmp #(.DATA_W(DATA_W)) i_cmp (
      .byte_in (rx_data),
      .pats    (pats),
      .eq      (eq)
   );

   swflow_seq i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .mode     (mode),
      .eq       (eq),
      .on_hit   (on_hit),
      .off_hit  (off_hit)
   );

   swflow_gate i_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_off  (mode == FC_OFF),
      .rx_valid  (rx_valid),
      .on_hit    (on_hit),
      .off_hit   (off_hit),
      .xon_any   (cfg_xon_any),
      .boundary  (tx_char_boundary),
      .suspended (flow_suspended),
      .tx_en     (tx_enable),
      .on_pulse  (xon_pulse),
      .off_pulse (xoff_pulse),
      .flow_flag (rx_is_flow)
   );
endmodule

// File: rtl/swflow_chk.sv
module swflow_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic [DATA_W-1:0] cfg_xoff1,
   input logic [DATA_W-1:0] cfg_xon1,
   input logic [1:0]        cfg_mode,
   input logic              tx_char_boundary,
   input logic              tx_enable,
   input logic              xon_pulse,
   input logic              xoff_pulse,
   input logic              flow_suspended,
   input logic              rx_is_flow
);
   a_r2_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'b00) |=> (tx_enable && !flow_suspended && !xon_pulse && !xoff_pulse));

   a_r3_xoff_pauses: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_mode == 2'b01 && rx_data == cfg_xoff1) |=> (flow_suspended && xoff_pulse));

   a_r3_xon_resumes: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_mode == 2'b01 && rx_data == cfg_xon1 && rx_data != cfg_xoff1)
      |=> !flow_suspended);

   a_r9_state_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flow_suspended) |-> ($past(rx_valid) || $past(cfg_mode == 2'b00)));

   a_r10_fall_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_enable) |-> ($past(tx_char_boundary) && $past(flow_suspended)));

   a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(xon_pulse && xoff_pulse));

   a_r11_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_is_flow |-> (xon_pulse || xoff_pulse));
endmodule

bind swflow_ctl swflow_chk #(.DATA_W(DATA_W)) i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .rx_valid         (rx_valid),
   .rx_data          (rx_data),
   .cfg_xoff1        (cfg_xoff1),
   .cfg_xon1         (cfg_xon1),
   .cfg_mode         (cfg_mode),
   .tx_char_boundary (tx_char_boundary),
   .tx_enable        (tx_enable),
   .xon_pulse        (xon_pulse),
   .xoff_pulse       (xoff_pulse),
   .flow_suspended   (flow_suspended),
   .rx_is_flow       (rx_is_flow)
);

// File: tb/test_swflow_ctl.sv
module test_swflow_ctl;
   localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h22, OFF1 = 8'h13, OFF2 = 8'h44, DAT = 8'h55;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic [7:0] cfg_xon1 = ON1, cfg_xon2 = ON2, cfg_xoff1 = OFF1, cfg_xoff2 = OFF2;
   logic [1:0] cfg_mode = 2'b00;
   logic       cfg_xon_any = 1'b0;
   logic       tx_char_boundary = 1'b1;
   logic       tx_enable, xon_pulse, xoff_pulse, flow_suspended, rx_is_flow;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   swflow_ctl #(.DATA_W(8)) i_swflow_ctl (.*);

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_data  = b;
      tick();
      rx_valid = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      cfg_mode = m;
      tick();
   endtask

   task automatic t_reset();
      chk("R1", "tx_enable", tx_enable, 1'b1);
      chk("R1", "flow_suspended", flow_suspended, 1'b0);
      chk("R1", "xon_pulse", xon_pulse, 1'b0);
      chk("R1", "xoff_pulse", xoff_pulse, 1'b0);
      chk("R1", "rx_is_flow", rx_is_flow, 1'b0);
   endtask

   task automatic t_single();
      set_mode(2'b01);
      send(OFF1);
      chk("R3", "suspended after xoff1", flow_suspended, 1'b1);
      chk("R11", "xoff_pulse", xoff_pulse, 1'b1);
      chk("R11", "rx_is_flow", rx_is_flow, 1'b1);
      chk("R10", "tx_enable lags", tx_enable, 1'b1);
      tick();
      chk("R10", "tx_enable low", tx_enable, 1'b0);
      chk("R11", "xoff_pulse one cycle", xoff_pulse, 1'b0);
      send(DAT);
      chk("R9", "data keeps pause", flow_suspended, 1'b1);
      chk("R9", "no xon_pulse", xon_pulse, 1'b0);
      send(ON1);
      chk("R3", "resumed by xon1", flow_suspended, 1'b0);
      chk("R11", "xon_pulse", xon_pulse, 1'b1);
      tick();
      chk("R10", "tx_enable back", tx_enable, 1'b1);
   endtask

   task automatic t_priority();
      cfg_xoff1 = ON1;
      send(ON1);
      chk("R4", "xoff_pulse wins", xoff_pulse, 1'b1);
      chk("R4", "xon_pulse suppressed", xon_pulse, 1'b0);
      chk("R4", "suspended", flow_suspended, 1'b1);
      cfg_xoff1 = OFF1;
      send(ON1);
      chk("R4", "resume after restore", flow_suspended, 1'b0);
      tick();
   endtask

   task automatic t_pair();
      set_mode(2'b10);
      send(OFF1);
      chk("R5", "first byte alone", flow_suspended, 1'b0);
      chk("R5", "no pulse on first", xoff_pulse, 1'b0);
      send(OFF2);
      chk("R5", "pair pauses", flow_suspended, 1'b1);
      chk("R11", "flag on completing byte", rx_is_flow, 1'b1);
      send(ON1);
      chk("R5", "half resume", flow_suspended, 1'b1);
      send(ON2);
      chk("R5", "pair resumes", flow_suspended, 1'b0);
      tick();
   endtask

   task automatic t_pair_break();
      send(OFF1);
      send(OFF1);
      chk("R6", "repeat first byte", flow_suspended, 1'b0);
      send(OFF2);
      chk("R6", "rechecked first byte", flow_suspended, 1'b1);
      send(ON1);
      send(DAT);
      send(ON2);
      chk("R6", "broken resume dropped", flow_suspended, 1'b1);
      chk("R6", "no xon_pulse", xon_pulse, 1'b0);
      send(ON1);
      send(ON2);
      chk("R6", "clean resume", flow_suspended, 1'b0);
      tick();
   endtask

   task automatic t_either();
      set_mode(2'b11);
      send(OFF2);
      chk("R7", "xoff2 alone pauses", flow_suspended, 1'b1);
      send(ON2);
      chk("R7", "xon2 alone resumes", flow_suspended, 1'b0);
      tick();
   endtask

   task automatic t_xon_any();
      set_mode(2'b01);
      cfg_xon_any = 1'b1;
      send(DAT);
      chk("R8", "no pulse while running", xon_pulse, 1'b0);
      send(OFF1);
      chk("R8", "paused", flow_suspended, 1'b1);
      send(DAT);
      chk("R8", "any byte resumes", flow_suspended, 1'b0);
      chk("R8", "xon_pulse", xon_pulse, 1'b1);
      chk("R8", "data not flagged", rx_is_flow, 1'b0);
      cfg_xon_any = 1'b0;
      tick();
   endtask

   task automatic t_boundary();
      tx_char_boundary = 1'b0;
      send(OFF1);
      repeat (3) tick();
      chk("R10", "held mid-character", tx_enable, 1'b1);
      tx_char_boundary = 1'b1;
      tick();
      chk("R10", "falls at boundary", tx_enable, 1'b0);
      send(ON1);
      chk("R10", "still low one cycle", tx_enable, 1'b0);
      tick();
      chk("R10", "rises after resume", tx_enable, 1'b1);
   endtask

   task automatic t_mode_off();
      send(OFF1);
      tick();
      chk("R2", "paused before off", tx_enable, 1'b0);
      set_mode(2'b00);
      chk("R2", "tx_enable forced", tx_enable, 1'b1);
      chk("R2", "state cleared", flow_suspended, 1'b0);
      send(OFF1);
      chk("R2", "no detection", xoff_pulse, 1'b0);
      chk("R2", "stays running", flow_suspended, 1'b0);
   endtask

   task automatic t_clear_partial();
      set_mode(2'b10);
      send(OFF1);
      set_mode(2'b00);
      set_mode(2'b10);
      send(OFF2);
      chk("R12", "partial discarded", flow_suspended, 1'b0);
      chk("R12", "no pulse", xoff_pulse, 1'b0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_single();
      t_priority();
      t_pair();
      t_pair_break();
      t_either();
      t_xon_any();
      t_boundary();
      t_mode_off();
      t_clear_partial();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule